// File: doc/BRIEF.md
# Acknowledged Link Packet Transmitter

This block is the sending half of a point-to-point link that must deliver packets reliably and in order, one hop at a time. Packets arrive from a local queue, each one data word with a priority. The block gives each packet a 5-bit sequence tag (ack ID) and keeps it in a replay store. It emits the packet as a start delimiter symbol followed by the data word. The start delimiter carries the ack ID and the priority. A packet stays stored until the partner acknowledges it.

The partner answers with feedback symbols, and each one names an ack ID. An accept frees storage. A retry makes the block send a restart symbol and rewind to the retried packet. A not-accepted symbol makes the block send a link-request, stop sending, and wait for a link-response. The link-response names the partner's next expected ack ID, and sending resumes from that packet. If no response arrives within a programmable number of cycles, the link-request is sent again. Any feedback that names no outstanding packet, or that comes in the wrong state, is dropped and flagged.

The output stream carries one item per cycle, with this code on `outKind`: 0 start-of-packet, 1 data, 2 end-of-packet, 3 restart-from-retry, 4 link-request. The feedback code on `fbKind` is: 0 accepted, 1 retry, 2 not-accepted, 3 link-response.

Top module: `txlink_top`

## Requirements
- R1: While reset is held and right after it, `outValid` and `protoErr` are 0 and `pktReady` is 1. The first packet accepted after reset gets ack ID 0.
- R2: Each packet is sent as a start item (kind 0) that carries its ack ID and priority, followed in the very next cycle by a data item (kind 1) that carries its word. Ack IDs go up by one per new packet, in arrival order, and wrap from 31 to 0.
- R3: After a data item, the next item is the start item of the next stored unsent packet if one is ready and no control symbol is pending. Otherwise it is an end-of-packet item (kind 2). An end-of-packet item only ever directly follows a data item.
- R4: `pktReady` is 0 while DEPTH packets are stored. An accepted symbol naming outstanding ack ID X frees every stored packet up to and including X.
- R5: A retry naming outstanding ack ID X makes the block emit one restart item (kind 3), after closing any open packet. It then re-sends the packets from X onward, in order.
- R6: A not-accepted symbol naming an outstanding ack ID makes the block emit one link-request item (kind 4). After that it emits no start item until a valid link-response arrives.
- R7: A link-response naming ack ID E, with E at most one past the last sent packet, frees the packets before E and resumes sending at E.
- R8: While the block waits for a link-response, the link-request is emitted again exactly `respTimeout` cycles after the previous one.
- R9: Feedback whose ack ID matches no outstanding sent packet, or a link-response that arrives when none is awaited, changes nothing. It raises `protoErr` for exactly one cycle, in the cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktValid | input | 1 | A packet is offered |
| pktReady | output | 1 | Replay store has room; the packet is taken when both are high |
| pktData | input | DATA_W | Packet data word |
| pktPrio | input | PRIO_W | Packet priority |
| fbValid | input | 1 | A feedback symbol is present |
| fbKind | input | 2 | Feedback code: 0 accepted, 1 retry, 2 not-accepted, 3 link-response |
| fbAck | input | ACK_W | Ack ID named by the feedback |
| respTimeout | input | TMR_W | Cycles between repeated link-requests |
| outValid | output | 1 | An output item is present |
| outKind | output | 3 | Item code: 0 start, 1 data, 2 end, 3 restart, 4 link-request |
| outAck | output | ACK_W | Ack ID on start items |
| outPrio | output | PRIO_W | Priority on start items |
| outData | output | DATA_W | Packet word on data items |
| protoErr | output | 1 | One-cycle pulse for dropped feedback |

## Verification
The hardest state to reach is a rewind deep inside a full replay store. The store must be filled to DEPTH with every packet sent but unacknowledged, and then a retry must name a packet in the middle. The bench gets there by first freeing part of a batch with a cumulative accept. It then refills until `pktReady` drops and waits for the stream to drain before it issues the retry. The error-recovery path is reached the same way. A new packet is pushed while the block is waiting, so it is proven held back, and the timeout run measures the cycle gap between two link-requests from a recorded log of the output stream.

// File: rtl/txlink_pkg.sv
package txlink_pkg;

  typedef enum logic [2:0] {
    KIND_SOP     = 3'd0,
    KIND_DATA    = 3'd1,
    KIND_EOP     = 3'd2,
    KIND_RESTART = 3'd3,
    KIND_LREQ    = 3'd4,
    KIND_IDLE    = 3'd7
  } outKind_e;

  typedef enum logic [1:0] {
    FB_ACC   = 2'd0,
    FB_RETRY = 2'd1,
    FB_NACC  = 2'd2,
    FB_LRESP = 2'd3
  } fbKind_e;

  // strobes from the controller to the replay store
  typedef struct packed {
    logic push;   // write the offered packet at the tail
    logic latch;  // capture the word at rdOff for the coming data item
  } strobe_t;

endpackage

// File: rtl/txlink_store.sv
module txlink_store
  import txlink_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRIO_W = 2,
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [CNT_W-1:0]  relN,
  input  logic [CNT_W-1:0]  rdOff,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PRIO_W-1:0] wrPrio,
  output logic [CNT_W-1:0]  cnt,
  output logic [PRIO_W-1:0] rdPrio,
  output logic [DATA_W-1:0] latchData
);

  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [PRIO_W-1:0] prioMem [DEPTH];
  logic [IDX_W-1:0]  headIdx;
  logic [IDX_W-1:0]  tailIdx;
  logic [IDX_W-1:0]  rdIdx;
  logic [IDX_W-1:0]  headNext;

  function automatic logic [IDX_W-1:0] wrapIdx(input logic [IDX_W:0] v);
    if (v >= (IDX_W+1)'(DEPTH)) return IDX_W'(v - (IDX_W+1)'(DEPTH));
    else return v[IDX_W-1:0];
  endfunction

  assign tailIdx  = wrapIdx({1'b0, headIdx} + (IDX_W+1)'(cnt));
  assign rdIdx    = wrapIdx({1'b0, headIdx} + (IDX_W+1)'(rdOff));
  assign headNext = wrapIdx({1'b0, headIdx} + (IDX_W+1)'(relN));
  assign rdPrio   = prioMem[rdIdx];

  always_ff @(posedge clk) begin
    if (strb.push) begin
      dataMem[tailIdx] <= wrData;
      prioMem[tailIdx] <= wrPrio;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx   <= '0;
      cnt       <= '0;
      latchData <= '0;
    end else begin
      headIdx <= headNext;
      cnt     <= cnt + CNT_W'(strb.push) - relN;
      if (strb.latch) latchData <= dataMem[rdIdx];
    end
  end

  // R4: the controller never writes into a full store
  assert_push_room_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (cnt < CNT_W'(DEPTH)));

  // R4: a release never frees more than is stored
  assert_release_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    relN <= cnt);

endmodule

// File: rtl/txlink_ctrl.sv
module txlink_ctrl
  import txlink_pkg::*;
#(
  parameter int ACK_W  = 5,
  parameter int PRIO_W = 2,
  parameter int DEPTH  = 8,
  parameter int TMR_W  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktValid,
  output logic              pktReady,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [PRIO_W-1:0] rdPrio,
  input  logic              fbValid,
  input  logic [1:0]        fbKind,
  input  logic [ACK_W-1:0]  fbAck,
  input  logic [TMR_W-1:0]  respTimeout,
  output strobe_t           strb,
  output logic [CNT_W-1:0]  relN,
  output logic [CNT_W-1:0]  rdOff,
  output logic              outValid,
  output logic [2:0]        outKind,
  output logic [ACK_W-1:0]  outAck,
  output logic [PRIO_W-1:0] outPrio,
  output logic              protoErr
);

  logic [ACK_W-1:0] headAck;
  logic [CNT_W-1:0] sendOff;
  logic             needData, openPkt, waiting, pendRestart, pendLreq;
  logic [TMR_W-1:0] timer;

  logic [ACK_W-1:0] fbOff;
  logic             matchSent, lrespInRange;
  logic             accEvt, retryEvt, naccEvt, lrespEvt, badEvt;
  logic             timeoutHit, ctlSym, blockSop;
  logic             emitValid, sopFire, lreqFire, restartFire;
  outKind_e         emitKind;

  // feedback classification against the outstanding window
  assign fbOff        = fbAck - headAck;
  assign matchSent    = {1'b0, fbOff} < (ACK_W+1)'(sendOff);
  assign lrespInRange = {1'b0, fbOff} <= (ACK_W+1)'(sendOff);
  assign accEvt   = fbValid && (fbKind == FB_ACC)   && matchSent;
  assign retryEvt = fbValid && (fbKind == FB_RETRY) && matchSent && !waiting;
  assign naccEvt  = fbValid && (fbKind == FB_NACC)  && matchSent && !waiting;
  assign lrespEvt = fbValid && (fbKind == FB_LRESP) && waiting && lrespInRange;
  assign badEvt   = fbValid && !(accEvt || retryEvt || naccEvt || lrespEvt);

  assign relN = accEvt   ? CNT_W'(fbOff) + CNT_W'(1) :
                lrespEvt ? CNT_W'(fbOff) : '0;

  assign timeoutHit = waiting && !pendLreq &&
                      (({1'b0, timer} + (TMR_W+1)'(1)) >= {1'b0, respTimeout});
  assign ctlSym   = pendRestart || ((pendLreq || timeoutHit) && !lrespEvt);
  assign blockSop = waiting || retryEvt || naccEvt || lrespEvt;

  always_comb begin
    emitValid   = 1'b0;
    emitKind    = KIND_IDLE;
    sopFire     = 1'b0;
    lreqFire    = 1'b0;
    restartFire = 1'b0;
    if (needData) begin
      emitValid = 1'b1;
      emitKind  = KIND_DATA;
    end else if (ctlSym) begin
      emitValid = 1'b1;
      if (openPkt) begin
        emitKind = KIND_EOP;
      end else if (pendRestart) begin
        emitKind    = KIND_RESTART;
        restartFire = 1'b1;
      end else begin
        emitKind = KIND_LREQ;
        lreqFire = 1'b1;
      end
    end else if (!blockSop && (sendOff < cnt)) begin
      emitValid = 1'b1;
      emitKind  = KIND_SOP;
      sopFire   = 1'b1;
    end else if (openPkt) begin
      emitValid = 1'b1;
      emitKind  = KIND_EOP;
    end
  end

  assign pktReady   = cnt < CNT_W'(DEPTH);
  assign strb.push  = pktValid && pktReady;
  assign strb.latch = sopFire;
  assign rdOff      = sendOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headAck     <= '0;
      sendOff     <= '0;
      needData    <= 1'b0;
      openPkt     <= 1'b0;
      waiting     <= 1'b0;
      pendRestart <= 1'b0;
      pendLreq    <= 1'b0;
      timer       <= '0;
      protoErr    <= 1'b0;
      outValid    <= 1'b0;
      outKind     <= KIND_IDLE;
      outAck      <= '0;
      outPrio     <= '0;
    end else begin
      headAck <= headAck + ACK_W'(relN);
      if (retryEvt)      sendOff <= CNT_W'(fbOff);
      else if (lrespEvt) sendOff <= '0;
      else               sendOff <= sendOff + CNT_W'(sopFire) - relN;

      needData <= sopFire;
      if (emitKind == KIND_DATA) openPkt <= 1'b1;
      else if (emitValid)        openPkt <= 1'b0;

      if (naccEvt)       waiting <= 1'b1;
      else if (lrespEvt) waiting <= 1'b0;

      if (naccEvt)                    pendLreq <= 1'b1;
      else if (lreqFire || lrespEvt)  pendLreq <= 1'b0;

      if (retryEvt)         pendRestart <= 1'b1;
      else if (restartFire) pendRestart <= 1'b0;

      if (lreqFire || naccEvt)        timer <= '0;
      else if (waiting && timer != '1) timer <= timer + TMR_W'(1);

      protoErr <= badEvt;
      outValid <= emitValid;
      outKind  <= emitKind;
      outAck   <= headAck + ACK_W'(sendOff);
      outPrio  <= rdPrio;
    end
  end

  // R2: a start item is always followed at once by its data item
  assert_data_after_sop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == KIND_SOP) |=> (outValid && outKind == KIND_DATA));

  // R3: an end item only closes a packet whose data was just sent
  assert_eop_after_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == KIND_EOP) |-> $past(outValid && outKind == KIND_DATA));

  // R6: no new packet starts while a link-response is awaited
  assert_no_sop_waiting_R6: assert property (@(posedge clk) disable iff (!rstN)
    waiting |=> !(outValid && outKind == KIND_SOP));

  // R9: dropped feedback frees nothing
  assert_bad_no_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> $stable(headAck));

endmodule

// File: rtl/txlink_top.sv
module txlink_top
  import txlink_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRIO_W = 2,
  parameter int ACK_W  = 5,
  parameter int DEPTH  = 8,
  parameter int TMR_W  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktValid,
  output logic              pktReady,
  input  logic [DATA_W-1:0] pktData,
  input  logic [PRIO_W-1:0] pktPrio,
  input  logic              fbValid,
  input  logic [1:0]        fbKind,
  input  logic [ACK_W-1:0]  fbAck,
  input  logic [TMR_W-1:0]  respTimeout,
  output logic              outValid,
  output logic [2:0]        outKind,
  output logic [ACK_W-1:0]  outAck,
  output logic [PRIO_W-1:0] outPrio,
  output logic [DATA_W-1:0] outData,
  output logic              protoErr
);

  strobe_t          strb;
  logic [CNT_W-1:0] relN, rdOff, cnt;
  logic [PRIO_W-1:0] rdPrio;

  txlink_ctrl #(.ACK_W(ACK_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH), .TMR_W(TMR_W)) ctrl (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktReady(pktReady),
    .cnt(cnt), .rdPrio(rdPrio), .fbValid(fbValid), .fbKind(fbKind),
    .fbAck(fbAck), .respTimeout(respTimeout), .strb(strb), .relN(relN),
    .rdOff(rdOff), .outValid(outValid), .outKind(outKind), .outAck(outAck),
    .outPrio(outPrio), .protoErr(protoErr)
  );

  txlink_store #(.DATA_W(DATA_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH)) store (
    .clk(clk), .rstN(rstN), .strb(strb), .relN(relN), .rdOff(rdOff),
    .wrData(pktData), .wrPrio(pktPrio), .cnt(cnt), .rdPrio(rdPrio),
    .latchData(outData)
  );

endmodule

// File: tb/txlink_top_test.sv
`timescale 1ns/1ps
module txlink_top_test;
  import txlink_pkg::*;

  localparam int TMO = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pktValid = 1'b0;
  logic        pktReady;
  logic [31:0] pktData = '0;
  logic [1:0]  pktPrio = '0;
  logic        fbValid = 1'b0;
  logic [1:0]  fbKind = '0;
  logic [4:0]  fbAck = '0;
  logic [15:0] respTimeout = 16'(TMO);
  logic        outValid;
  logic [2:0]  outKind;
  logic [4:0]  outAck;
  logic [1:0]  outPrio;
  logic [31:0] outData;
  logic        protoErr;

  txlink_top uut (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktReady(pktReady),
    .pktData(pktData), .pktPrio(pktPrio), .fbValid(fbValid), .fbKind(fbKind),
    .fbAck(fbAck), .respTimeout(respTimeout), .outValid(outValid),
    .outKind(outKind), .outAck(outAck), .outPrio(outPrio), .outData(outData),
    .protoErr(protoErr)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int logN = 0;
  logic [2:0]  logKind [1024];
  logic [4:0]  logAck  [1024];
  logic [1:0]  logPrio [1024];
  logic [31:0] logData [1024];
  int          logCyc  [1024];
  logic [31:0] expDat [32];
  logic [1:0]  expPri [32];
  int pushIdx = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN && outValid && logN < 1024) begin
      logKind[logN] = outKind;
      logAck[logN]  = outAck;
      logPrio[logN] = outPrio;
      logData[logN] = outData;
      logCyc[logN]  = cyc;
      logN = logN + 1;
    end
  end

  // stimulus vectors: {data, priority, expected ack ID}
  localparam logic [38:0] vecTab [4] = '{
    {32'hA5A5_0001, 2'd3, 5'd0},
    {32'h0BAD_F00D, 2'd0, 5'd1},
    {32'h1234_5678, 2'd1, 5'd2},
    {32'hFFFF_0000, 2'd2, 5'd3}
  };

  task automatic chkEq(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushPkt(input logic [31:0] d, input logic [1:0] p);
    pktValid = 1'b1; pktData = d; pktPrio = p;
    expDat[pushIdx % 32] = d; expPri[pushIdx % 32] = p;
    pushIdx++;
    @(negedge clk);
    pktValid = 1'b0;
  endtask

  task automatic sendFb(input logic [1:0] k, input logic [4:0] a);
    fbValid = 1'b1; fbKind = k; fbAck = a;
    @(negedge clk);
    fbValid = 1'b0;
  endtask

  // checks one start+data pair at log index i against ack a
  task automatic chkPkt(input string tag, input int i, input int a);
    chkEq({tag, " start kind"}, logKind[i], KIND_SOP);
    chkEq({tag, " start ack"}, logAck[i], a % 32);
    chkEq({tag, " start prio"}, logPrio[i], expPri[a % 32]);
    chkEq({tag, " data kind"}, logKind[i+1], KIND_DATA);
    chkEq({tag, " data word"}, logData[i+1], expDat[a % 32]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int mark, accepted, lreqs, firstL, secondL;
    waitCyc(3);
    // R1: reset state
    chkEq("R1 outValid in reset", outValid, 0);
    chkEq("R1 pktReady in reset", pktReady, 1);
    chkEq("R1 protoErr in reset", protoErr, 0);
    rstN = 1'b1;
    waitCyc(2);
    chkEq("R1 outValid after reset", outValid, 0);

    // R2/R3: table of back-to-back packets
    mark = logN;
    for (int i = 0; i < 4; i++) begin
      pktValid = 1'b1; pktData = vecTab[i][38:7]; pktPrio = vecTab[i][6:5];
      expDat[pushIdx] = vecTab[i][38:7]; expPri[pushIdx] = vecTab[i][6:5];
      pushIdx++;
      @(negedge clk);
    end
    pktValid = 1'b0;
    waitCyc(12);
    chkEq("R2 table item count", logN - mark, 9);
    for (int i = 0; i < 4; i++) begin
      chkPkt("R2 table", mark + 2*i, int'(vecTab[i][4:0]));
    end
    chkEq("R3 end after last data", logKind[mark+8], KIND_EOP);

    // R4: cumulative accept of ack 1, then fill until full
    sendFb(FB_ACC, 5'd1);
    accepted = 0;
    for (int i = 0; i < 12; i++) begin
      if (pktReady) begin
        pktValid = 1'b1; pktData = 32'h4000_0000 + 32'(i); pktPrio = 2'(i);
        expDat[pushIdx % 32] = pktData; expPri[pushIdx % 32] = pktPrio;
        pushIdx++; accepted++;
      end else pktValid = 1'b0;
      @(negedge clk);
    end
    pktValid = 1'b0;
    chkEq("R4 packets taken until full", accepted, 6);
    chkEq("R4 pktReady low when full", pktReady, 0);
    waitCyc(20);

    // R5: retry in the middle of the full store
    mark = logN;
    sendFb(FB_RETRY, 5'd5);
    waitCyc(16);
    chkEq("R5 replay item count", logN - mark, 12);
    chkEq("R5 restart first", logKind[mark], KIND_RESTART);
    for (int i = 0; i < 5; i++) chkPkt("R5 replay", mark + 1 + 2*i, 5 + i);
    chkEq("R5 end after replay", logKind[mark+11], KIND_EOP);
    sendFb(FB_ACC, 5'd9);
    @(negedge clk);
    chkEq("R4 pktReady after full release", pktReady, 1);

    // R6/R7: not-accepted, hold, link-response
    pushPkt(32'hCAFE_000A, 2'd1);
    pushPkt(32'hCAFE_000B, 2'd2);
    waitCyc(10);
    mark = logN;
    sendFb(FB_NACC, 5'd11);
    pushPkt(32'hCAFE_000C, 2'd3);
    waitCyc(10);
    chkEq("R6 only one item while waiting", logN - mark, 1);
    chkEq("R6 link-request emitted", logKind[mark], KIND_LREQ);
    mark = logN;
    sendFb(FB_LRESP, 5'd11);
    waitCyc(10);
    chkEq("R7 resume item count", logN - mark, 5);
    chkPkt("R7 resume at 11", mark, 11);
    chkPkt("R7 then 12", mark + 2, 12);
    chkEq("R7 end after resume", logKind[mark+4], KIND_EOP);
    sendFb(FB_ACC, 5'd12);

    // R8: link-request repeated after the timeout
    pushPkt(32'hBEEF_000D, 2'd0);
    waitCyc(8);
    mark = logN;
    sendFb(FB_NACC, 5'd13);
    waitCyc(TMO + 10);
    lreqs = 0; firstL = 0; secondL = 0;
    for (int i = mark; i < logN; i++) begin
      if (logKind[i] == KIND_LREQ) begin
        if (lreqs == 0) firstL = logCyc[i];
        if (lreqs == 1) secondL = logCyc[i];
        lreqs++;
      end
    end
    chkEq("R8 link-request count", lreqs, 2);
    chkEq("R8 repeat gap", secondL - firstL, TMO);
    chkEq("R8 only link-requests", logN - mark, 2);
    sendFb(FB_LRESP, 5'd14);
    waitCyc(4);
    chkEq("R7 response frees 13", pktReady, 1);

    // R9: unmatched feedback is dropped and flagged
    mark = logN;
    sendFb(FB_ACC, 5'd20);
    chkEq("R9 protoErr on stray accept", protoErr, 1);
    @(negedge clk);
    chkEq("R9 protoErr one cycle", protoErr, 0);
    sendFb(FB_LRESP, 5'd14);
    chkEq("R9 protoErr on unawaited response", protoErr, 1);
    sendFb(FB_RETRY, 5'd3);
    chkEq("R9 protoErr on stray retry", protoErr, 1);
    waitCyc(4);
    chkEq("R9 stray feedback emits nothing", logN - mark, 0);
    mark = logN;
    pushPkt(32'hD00D_000E, 2'd2);
    waitCyc(6);
    chkPkt("R9 ack state unchanged", mark, 14);

    // R2: ack IDs wrap from 31 to 0
    sendFb(FB_ACC, 5'd14);
    for (int i = 0; i < 20; i++) begin
      mark = logN;
      pushPkt(32'h5000_0000 + 32'(i), 2'(i));
      waitCyc(5);
      chkPkt("R2 wrap", mark, pushIdx - 1);
      sendFb(FB_ACC, 5'((pushIdx - 1) % 32));
    end
    waitCyc(3);
    chkEq("R1 protoErr quiet at end", protoErr, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule